// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block is the device-side controller that turns a multi-write host sequence into one buffered program operation on a small word-addressed array. The host opens the sequence with a setup command and then writes a word count (encoded as count minus one). It follows with address/data pairs that fill a write buffer of up to 32 words, and closes with a confirm command. Every write arrives on a simple synchronous bus: one strobe, an address and a data word per cycle.

After a valid confirm, the block enters a busy phase whose length is set by a cycle counter. The phase is twice as long when the buffered span runs past a 32-word alignment boundary. At the end of the busy phase, the written buffer slots are copied into the array. Progress and errors are reported in an 8-bit status byte that the host reads on the same bus. Reads return either the status byte or array contents, selected by commands. A test-only input forces the modeled program step to fail.

Top module: `flash_bufprog_seq`

## Requirements
- R1: After reset, reads return status mode with the status byte 0x80, and every array word reads 0xFFFF once array mode is selected. In the status byte, bit 7 = ready, bit 5 = sequence error and bit 4 = program error; all other bits read 0.
- R2: A setup write (low byte 0xE8) is handled as follows:
  - With bit 4 clear, it starts a sequence and selects status reads, which show bit 7 set.
  - With bit 4 set, it is refused. The status byte then reads bit 7 clear with the error bits unchanged, and no sequence starts.
- R3: The write after setup carries count minus one in its low byte. A value above 31 aborts the sequence with status 0xB0.
- R4: The first data write fixes the start address. Every later data address must lie in start through start plus count minus one. An address outside that window, or a window that runs past the top array address, aborts with status 0xB0 and leaves the array unchanged.
- R5: After the counted data writes, only a write of low byte 0xD0 to an address in the same block as the setup write is accepted. A block is the address bits above bit 5. Any other write aborts with status 0xB0 and the array unchanged.
- R6: While programming runs, status reads 0x00 (bit 7 clear). When the span does not cross a 32-word boundary, bit 7 stays clear for exactly PROG_CYCLES cycles after the confirm edge, and the status then reads 0x80.
- R7: When start address bits [4:0] plus count minus one exceed 31, the busy time is exactly twice PROG_CYCLES. A full aligned 32-word span is not a crossing.
- R8: On completion, each address written in the sequence holds its last written data, and addresses not written keep their old content.
- R9: If the fail input is high when programming completes, the array is left unchanged and the status reads 0x90.
- R10: A write of low byte 0x50 clears bits 5 and 4. A write of 0xFF selects array reads, and a write of 0x70 selects status reads.
- R11: Writes that arrive while programming runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Word address for writes and reads |
| wdata | input | DATA_W | Write data; commands use the low byte |
| prog_fail_inj | input | 1 | Test-only: forces the modeled program step to fail |
| rdata | output | DATA_W | Status byte (zero-extended) or array word at addr |

## Verification
A wrong sequence state shows up at the first read after the offending write. The status byte then shows a missing or spurious 0xB0, or a ready bit that does not drop after confirm. A fault in the crossing flag or in the busy counter shows up only as the length of the ready-low window, so the bench counts that window cycle by cycle for an aligned span, a crossing span and a full 32-word span. A fault in buffer indexing or slot validity stays hidden until programming completes; it is then caught by reading back written, rewritten and skipped addresses in array mode.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COUNT,
      ST_FIRST,
      ST_LOAD,
      ST_CONFIRM,
      ST_BUSY
   } seq_state_e;

   localparam logic [7:0] OP_SETUP   = 8'hE8;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_CLRSTS  = 8'h50;
   localparam logic [7:0] OP_RDSTS   = 8'h70;
   localparam logic [7:0] OP_RDARR   = 8'hFF;

   localparam int SB_READY = 7;
   localparam int SB_SEQ   = 5;
   localparam int SB_PROG  = 4;
endpackage

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 16,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         we,
   input  logic [IDX_W-1:0]             idx,
   input  logic [DATA_W-1:0]            wdata,
   output logic [DEPTH-1:0][DATA_W-1:0] slot_data,
   output logic [DEPTH-1:0]             slot_vld
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [DATA_W-1:0] data_q;
      logic              vld_q;
      logic              hit;

      assign hit = we && (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q <= '1;
            vld_q  <= 1'b0;
         end else if (clr) begin
            vld_q  <= 1'b0;
         end else if (hit) begin
            data_q <= wdata;
            vld_q  <= 1'b1;
         end
      end

      assign slot_data[g] = data_q;
      assign slot_vld[g]  = vld_q;
   end
endmodule

// File: rtl/fbp_timer.sv
module fbp_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (busy) cnt_q <= cnt_q - CNT_W'(1);
   end
endmodule

// File: rtl/fbp_array.sv
module fbp_array #(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 16,
   parameter int SLOTS     = 32,
   parameter bit FLASH_AND = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   input  logic                         prog_en,
   input  logic [ADDR_W-1:0]            prog_base,
   input  logic [SLOTS-1:0][DATA_W-1:0] slot_data,
   input  logic [SLOTS-1:0]             slot_vld
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   assign rd_data = mem[rd_addr];

   if (FLASH_AND) begin : g_and
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '1;
         end else if (prog_en) begin
            for (int i = 0; i < SLOTS; i++)
               if (slot_vld[i])
                  mem[prog_base + ADDR_W'(i)] <= mem[prog_base + ADDR_W'(i)] & slot_data[i];
         end
      end
   end else begin : g_ovr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '1;
         end else if (prog_en) begin
            for (int i = 0; i < SLOTS; i++)
               if (slot_vld[i]) mem[prog_base + ADDR_W'(i)] <= slot_data[i];
         end
      end
   end
endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
   import fbp_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 16,
   parameter int BUF_WORDS   = 32,
   parameter int BLK_W       = 6,
   parameter int PROG_CYCLES = 16,
   parameter bit FLASH_AND   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              prog_fail_inj,
   output logic [DATA_W-1:0] rdata
);
   localparam int BUF_AW = $clog2(BUF_WORDS);
   localparam int TMR_W  = $clog2(2 * PROG_CYCLES + 1);
   localparam int BLK_HI = ADDR_W - BLK_W;
   localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

   if (BUF_WORDS < 2 || (BUF_WORDS & (BUF_WORDS - 1)) != 0 || BUF_WORDS > 128)
      begin : g_bad_buf
         $error("BUF_WORDS must be a power of two between 2 and 128");
      end
   if (BLK_W < BUF_AW || BLK_W >= ADDR_W) begin : g_bad_blk
      $error("BLK_W must cover the buffer and leave at least one block bit");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold an 8-bit command");
   end
   if (PROG_CYCLES < 1) begin : g_bad_cyc
      $error("PROG_CYCLES must be at least 1");
   end

   seq_state_e        state_q;
   logic [BLK_HI-1:0] blk_q;
   logic [ADDR_W-1:0] start_q;
   logic [BUF_AW-1:0] cnt_m1_q;
   logic [BUF_AW-1:0] left_q;
   logic              cross_q;
   logic              sr_seq_q;
   logic              sr_prog_q;
   logic              refused_q;
   logic              stat_mode_q;

   logic [7:0]        op;
   logic              cnt_ok;
   logic              top_ovf;
   logic [ADDR_W-1:0] offs;
   logic              in_rng;
   logic              span_cross;
   logic              setup_ok;
   logic              confirm_ok;
   logic              first_ok;
   logic              load_ok;
   logic              buf_we;
   logic [BUF_AW-1:0] buf_idx;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_busy;
   logic              tmr_done;
   logic              prog_go;
   logic [7:0]        status;
   logic [DATA_W-1:0] arr_rd;

   logic [BUF_WORDS-1:0][DATA_W-1:0] slot_data;
   logic [BUF_WORDS-1:0]             slot_vld;

   assign op      = wdata[7:0];
   assign cnt_ok  = (op <= 8'(BUF_WORDS - 1));
   assign top_ovf = (addr > (ADDR_MAX - ADDR_W'(cnt_m1_q)));
   assign offs    = addr - start_q;
   assign in_rng  = (offs <= ADDR_W'(cnt_m1_q));
   assign span_cross = (({1'b0, addr[BUF_AW-1:0]} + {1'b0, cnt_m1_q})
                        >= (BUF_AW + 1)'(BUF_WORDS));

   assign setup_ok   = wr_en && (state_q == ST_IDLE) && (op == OP_SETUP) && !sr_prog_q;
   assign confirm_ok = wr_en && (state_q == ST_CONFIRM) && (op == OP_CONFIRM)
                       && (addr[ADDR_W-1:BLK_W] == blk_q);
   assign first_ok   = wr_en && (state_q == ST_FIRST) && !top_ovf;
   assign load_ok    = wr_en && (state_q == ST_LOAD) && in_rng;
   assign buf_we     = first_ok || load_ok;
   assign buf_idx    = (state_q == ST_FIRST) ? '0 : offs[BUF_AW-1:0];
   assign tmr_val    = cross_q ? TMR_W'(2 * PROG_CYCLES) : TMR_W'(PROG_CYCLES);
   assign prog_go    = tmr_done && !prog_fail_inj;

   always_comb begin
      status           = 8'h00;
      status[SB_READY] = (state_q != ST_BUSY) && !refused_q;
      status[SB_SEQ]   = sr_seq_q;
      status[SB_PROG]  = sr_prog_q;
   end

   assign rdata = (stat_mode_q || state_q != ST_IDLE) ? DATA_W'(status) : arr_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         blk_q       <= '0;
         start_q     <= '0;
         cnt_m1_q    <= '0;
         left_q      <= '0;
         cross_q     <= 1'b0;
         sr_seq_q    <= 1'b0;
         sr_prog_q   <= 1'b0;
         refused_q   <= 1'b0;
         stat_mode_q <= 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (wr_en) begin
                  case (op)
                     OP_SETUP: begin
                        stat_mode_q <= 1'b1;
                        if (sr_prog_q) begin
                           refused_q <= 1'b1;
                        end else begin
                           refused_q <= 1'b0;
                           blk_q     <= addr[ADDR_W-1:BLK_W];
                           state_q   <= ST_COUNT;
                        end
                     end
                     OP_CLRSTS: begin
                        sr_seq_q  <= 1'b0;
                        sr_prog_q <= 1'b0;
                        refused_q <= 1'b0;
                     end
                     OP_RDSTS: begin
                        stat_mode_q <= 1'b1;
                        refused_q   <= 1'b0;
                     end
                     OP_RDARR: begin
                        stat_mode_q <= 1'b0;
                        refused_q   <= 1'b0;
                     end
                     default: ;
                  endcase
               end
            end
            ST_COUNT: begin
               if (wr_en) begin
                  if (cnt_ok) begin
                     cnt_m1_q <= op[BUF_AW-1:0];
                     state_q  <= ST_FIRST;
                  end else begin
                     sr_seq_q  <= 1'b1;
                     sr_prog_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            ST_FIRST: begin
               if (wr_en) begin
                  if (!top_ovf) begin
                     start_q <= addr;
                     cross_q <= span_cross;
                     left_q  <= cnt_m1_q;
                     state_q <= (cnt_m1_q == '0) ? ST_CONFIRM : ST_LOAD;
                  end else begin
                     sr_seq_q  <= 1'b1;
                     sr_prog_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            ST_LOAD: begin
               if (wr_en) begin
                  if (in_rng) begin
                     left_q <= left_q - BUF_AW'(1);
                     if (left_q == BUF_AW'(1)) state_q <= ST_CONFIRM;
                  end else begin
                     sr_seq_q  <= 1'b1;
                     sr_prog_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            ST_CONFIRM: begin
               if (wr_en) begin
                  if (confirm_ok) begin
                     state_q <= ST_BUSY;
                  end else begin
                     sr_seq_q  <= 1'b1;
                     sr_prog_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            ST_BUSY: begin
               if (tmr_done) begin
                  state_q <= ST_IDLE;
                  if (prog_fail_inj) sr_prog_q <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   fbp_wbuf #(
      .DEPTH (BUF_WORDS),
      .DATA_W(DATA_W),
      .IDX_W (BUF_AW)
   ) wbuf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (setup_ok),
      .we       (buf_we),
      .idx      (buf_idx),
      .wdata    (wdata),
      .slot_data(slot_data),
      .slot_vld (slot_vld)
   );

   fbp_timer #(
      .CNT_W(TMR_W)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (confirm_ok),
      .load_val(tmr_val),
      .busy    (tmr_busy),
      .done    (tmr_done)
   );

   fbp_array #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SLOTS    (BUF_WORDS),
      .FLASH_AND(FLASH_AND)
   ) array_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_addr  (addr),
      .rd_data  (arr_rd),
      .prog_en  (prog_go),
      .prog_base(start_q),
      .slot_data(slot_data),
      .slot_vld (slot_vld)
   );
endmodule

// File: rtl/flash_bufprog_seq_chk.sv
module flash_bufprog_seq_chk
   import fbp_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int BUF_WORDS   = 32,
   parameter int PROG_CYCLES = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input seq_state_e        state_q,
   input logic              sr_seq_q,
   input logic              sr_prog_q,
   input logic              tmr_busy
);
   logic [15:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_cnt <= '0;
      else if (tmr_busy) run_cnt <= run_cnt + 16'd1;
      else               run_cnt <= '0;
   end

   // R6
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BUSY) |-> !rdata[SB_READY]);

   // R10
   clr_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && wr_en && wdata[7:0] == OP_CLRSTS) |=> (!sr_seq_q && !sr_prog_q));

   // R5
   seq_implies_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_seq_q |-> sr_prog_q);

   // R3
   cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COUNT && wr_en && wdata[7:0] > 8'(BUF_WORDS - 1))
      |=> (sr_seq_q && state_q == ST_IDLE));

   // R7
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= 16'(2 * PROG_CYCLES));

   // R11
   busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BUSY) |=> (state_q == ST_BUSY || state_q == ST_IDLE));

   // R2
   setup_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && wr_en && wdata[7:0] == OP_SETUP && sr_prog_q)
      |=> (state_q == ST_IDLE && !rdata[SB_READY]));
endmodule

bind flash_bufprog_seq flash_bufprog_seq_chk #(
   .DATA_W     (DATA_W),
   .BUF_WORDS  (BUF_WORDS),
   .PROG_CYCLES(PROG_CYCLES)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wdata    (wdata),
   .rdata    (rdata),
   .state_q  (state_q),
   .sr_seq_q (sr_seq_q),
   .sr_prog_q(sr_prog_q),
   .tmr_busy (tmr_busy)
);

// File: tb/flash_bufprog_seq_tb_top.sv
`timescale 1ns/1ps
module flash_bufprog_seq_tb_top;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [6:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic        prog_fail_inj = 1'b0;
   logic [15:0] rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   flash_bufprog_seq #(
      .ADDR_W(7), .DATA_W(16), .BUF_WORDS(32), .BLK_W(6), .PROG_CYCLES(N)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .prog_fail_inj(prog_fail_inj), .rdata(rdata)
   );

   // monitor: pops one expected read per falling edge
   always @(negedge clk) begin
      logic [15:0] e;
      string t;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
         end
      end
   end

   task automatic wr(input logic [6:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [6:0] a, input logic [15:0] e, input string tag);
      @(posedge clk); #1;
      addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk); #1;
   endtask

   task automatic tally(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic measure_busy(input int exp, input string tag);
      int n = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (rdata[7] == 1'b0) n++;
         else break;
      end
      tally(n == exp, tag, n, exp);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual=expired expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_chk(7'h05, 16'h0080, "R1 reset status");
      wr(7'h00, 16'h00FF);
      rd_chk(7'h05, 16'hFFFF, "R1 erased array");

      // R2/R6/R8 aligned four-word program, out-of-order addresses
      wr(7'h40, 16'h00E8);
      rd_chk(7'h40, 16'h0080, "R2 setup ready");
      wr(7'h40, 16'h0003);
      wr(7'h40, 16'h1111);
      wr(7'h42, 16'h3333);
      wr(7'h41, 16'h2222);
      wr(7'h43, 16'h4444);
      wr(7'h45, 16'h00D0);
      measure_busy(N, "R6 aligned busy length");
      rd_chk(7'h00, 16'h0080, "R6 ready after done");
      wr(7'h00, 16'h00FF);
      rd_chk(7'h40, 16'h1111, "R8 word0");
      rd_chk(7'h41, 16'h2222, "R8 word1");
      rd_chk(7'h42, 16'h3333, "R8 word2");
      rd_chk(7'h43, 16'h4444, "R8 word3");
      rd_chk(7'h44, 16'hFFFF, "R8 neighbour untouched");

      // R7 crossing span, duplicate address and skipped address
      wr(7'h00, 16'h00E8);
      wr(7'h00, 16'h0003);
      wr(7'h1E, 16'hAAAA);
      wr(7'h1F, 16'hBBBB);
      wr(7'h1E, 16'hCCCC);
      wr(7'h21, 16'hDDDD);
      wr(7'h00, 16'h00D0);
      measure_busy(2 * N, "R7 crossing busy length");
      wr(7'h00, 16'h00FF);
      rd_chk(7'h1E, 16'hCCCC, "R8 last write wins");
      rd_chk(7'h1F, 16'hBBBB, "R8 word 1F");
      rd_chk(7'h20, 16'hFFFF, "R8 skipped word");
      rd_chk(7'h21, 16'hDDDD, "R8 word 21");

      // R7 full aligned 32-word span is not a crossing
      wr(7'h00, 16'h00E8);
      wr(7'h00, 16'h001F);
      for (int i = 0; i < 32; i++) wr(7'(i), 16'(16'h0500 + i));
      wr(7'h10, 16'h00D0);
      measure_busy(N, "R7 full aligned busy length");
      wr(7'h00, 16'h00FF);
      rd_chk(7'h00, 16'h0500, "R8 full span first");
      rd_chk(7'h1F, 16'h051F, "R8 full span last");

      // R3 count too large, then R2 refusal, R10 clear
      wr(7'h00, 16'h00E8);
      wr(7'h00, 16'h0020);
      rd_chk(7'h00, 16'h00B0, "R3 count above limit");
      wr(7'h00, 16'h00E8);
      rd_chk(7'h00, 16'h0030, "R2 setup refused");
      wr(7'h00, 16'h0050);
      rd_chk(7'h00, 16'h0080, "R10 clear status");

      // R4 out-of-window address
      wr(7'h50, 16'h00E8);
      wr(7'h50, 16'h0001);
      wr(7'h50, 16'h1234);
      wr(7'h52, 16'h5678);
      rd_chk(7'h00, 16'h00B0, "R4 address outside window");
      wr(7'h00, 16'h0050);
      wr(7'h00, 16'h00FF);
      rd_chk(7'h50, 16'hFFFF, "R4 array untouched");

      // R4 window past top of array
      wr(7'h7F, 16'h00E8);
      wr(7'h7F, 16'h0001);
      wr(7'h7F, 16'h9999);
      rd_chk(7'h00, 16'h00B0, "R4 window past top");
      wr(7'h00, 16'h0050);

      // R5 wrong command at confirm step
      wr(7'h48, 16'h00E8);
      wr(7'h48, 16'h0000);
      wr(7'h48, 16'h1234);
      wr(7'h48, 16'h0070);
      rd_chk(7'h00, 16'h00B0, "R5 wrong confirm command");
      wr(7'h00, 16'h0050);
      // R5 confirm in another block
      wr(7'h48, 16'h00E8);
      wr(7'h48, 16'h0000);
      wr(7'h48, 16'h1234);
      wr(7'h08, 16'h00D0);
      rd_chk(7'h00, 16'h00B0, "R5 confirm wrong block");
      wr(7'h00, 16'h0050);
      wr(7'h00, 16'h00FF);
      rd_chk(7'h48, 16'hFFFF, "R5 array untouched");

      // R9 forced failure
      wr(7'h60, 16'h00E8);
      wr(7'h60, 16'h0000);
      wr(7'h60, 16'h5555);
      prog_fail_inj = 1'b1;
      wr(7'h60, 16'h00D0);
      measure_busy(N, "R9 busy before failure");
      prog_fail_inj = 1'b0;
      rd_chk(7'h00, 16'h0090, "R9 failure status");
      wr(7'h60, 16'h00E8);
      rd_chk(7'h00, 16'h0010, "R2 refused after failure");
      wr(7'h00, 16'h0050);
      wr(7'h00, 16'h00FF);
      rd_chk(7'h60, 16'hFFFF, "R9 array untouched");

      // R11 writes during busy ignored; R6 status during busy
      wr(7'h70, 16'h00E8);
      wr(7'h70, 16'h0000);
      wr(7'h70, 16'hAAAA);
      wr(7'h70, 16'h00D0);
      rd_chk(7'h00, 16'h0000, "R6 status while busy");
      wr(7'h70, 16'h00E8);
      wr(7'h70, 16'h0000);
      wr(7'h70, 16'h0003);
      repeat (2 * N) @(posedge clk);
      rd_chk(7'h00, 16'h0080, "R11 idle after busy");
      wr(7'h71, 16'h0003);
      wr(7'h00, 16'h00FF);
      rd_chk(7'h70, 16'hAAAA, "R11 busy writes ignored");
      rd_chk(7'h71, 16'hFFFF, "R11 no stray program");

      // R10 status read mode select
      wr(7'h00, 16'h0070);
      rd_chk(7'h70, 16'h0080, "R10 status read select");

      repeat (2) @(posedge clk);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule